// File: doc/BRIEF.md
# Power-Fail Bank Enable Guard

This block sits between a memory controller and up to four banks of static RAM that are kept alive by a backup cell. It turns one active-low chip-enable request and a bank-select code into one active-low enable per bank. While supply power is good, the enable of the addressed bank follows the request directly, with no clock delay. Every other bank stays disabled.

The analog supply monitor is represented by two digital trip flags. `trip_tight` trips at the narrow-tolerance point and `trip_wide` at the wide-tolerance point. A tolerance-select input decides which of the two flags counts as a supply fault.

When a fault appears while no access is open, every bank is shut at once. When a fault appears during an open access, that access may finish on its own bank, but only for a bounded number of clock cycles. After the access ends, or the grace window runs out, all banks stay shut. They reopen only once the selected flag is clear and the request is idle. Reset also leaves the banks shut.

Top module: `nvg_bank_guard`

## Requirements
- R1: While `rst_n` is low, and right after it rises, every bit of `bank_ce_n` is 1.
- R2: In normal operation, `bank_ce_n[k]` equals `ce_in_n` when `bank_sel` equals k, and is 1 for every other k. The output follows the inputs in the same cycle.
- R3: The supply fault is `trip_tight` when `wide_tol` is 0 and `trip_wide` when `wide_tol` is 1. The flag that is not selected has no effect on `bank_ce_n`.
- R4: If the fault is seen at a clock edge while `ce_in_n` is 1, every output is 1 from then on. This holds even if `ce_in_n` later goes low.
- R5: If the fault is seen at a clock edge while `ce_in_n` is 0, the bank addressed at that edge keeps following `ce_in_n`. All other outputs are 1, even if `bank_sel` changes.
- R6: A grace access ends at the first clock edge where `ce_in_n` is 1. After that, every output is 1 regardless of `ce_in_n`.
- R7: A grace access that is still open GRACE_CYCLES clock edges after the detection edge is cut off. From then on, every output is 1.
- R8: Shut banks reopen only after a clock edge at which the selected fault flag is 0 and `ce_in_n` is 1. An edge with `ce_in_n` at 0 keeps them shut.
- R9: At most one bit of `bank_ce_n` is 0 at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_sel | input | $clog2(NUM_BANKS) | Bank address code |
| ce_in_n | input | 1 | Active-low access request |
| wide_tol | input | 1 | 0: use `trip_tight`, 1: use `trip_wide` |
| trip_tight | input | 1 | Narrow-tolerance supply trip flag, 1 = fault |
| trip_wide | input | 1 | Wide-tolerance supply trip flag, 1 = fault |
| bank_ce_n | output | NUM_BANKS | Active-low per-bank enables |

## Verification
The bench builds the guard with four banks and GRACE_CYCLES set to 5. With that setting, a request held low longer than the grace window reaches the forced cut-off within a short run. It also lets an access that ends inside the window be told apart from one that is cut off. Four banks let the test confirm that a select change during grace does not move the open bank. Both tolerance settings are run, and each is driven with the other flag toggling.

// File: rtl/nvg_pkg.sv
package nvg_pkg;

   typedef enum logic [1:0] {
      GS_SHUT  = 2'd0,
      GS_RUN   = 2'd1,
      GS_GRACE = 2'd2
   } guard_state_e;

endpackage

// File: rtl/nvg_trip_pick.sv
module nvg_trip_pick #(
   parameter int NUM_LEVELS = 2,
   localparam int LVL_W = (NUM_LEVELS > 1) ? $clog2(NUM_LEVELS) : 1
) (
   input  logic [NUM_LEVELS-1:0] trip_vec,
   input  logic [LVL_W-1:0]      level_sel,
   output logic                  fault
);

   generate
      if (NUM_LEVELS == 1) begin : g_single
         logic unused_sel;
         assign unused_sel = ^level_sel;
         assign fault = trip_vec[0];
      end else if (NUM_LEVELS == 2) begin : g_pair
         assign fault = level_sel[0] ? trip_vec[1] : trip_vec[0];
      end else begin : g_many
         always_comb begin
            fault = 1'b1;
            for (int i = 0; i < NUM_LEVELS; i++) begin
               if (level_sel == LVL_W'(i)) fault = trip_vec[i];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/nvg_guard_fsm.sv
module nvg_guard_fsm
   import nvg_pkg::*;
#(
   parameter int SEL_W        = 2,
   parameter int GRACE_CYCLES = 8,
   localparam int CNT_W = (GRACE_CYCLES > 1) ? $clog2(GRACE_CYCLES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fault,
   input  logic             ce_in_n,
   input  logic [SEL_W-1:0] bank_sel,
   output guard_state_e     state,
   output logic [SEL_W-1:0] held_sel
);

   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(GRACE_CYCLES - 1);

   guard_state_e     st_q;
   logic [SEL_W-1:0] held_q;
   logic [CNT_W-1:0] age_q;
   logic             age_done;

   assign age_done = (age_q == LAST_CNT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= GS_SHUT;
         held_q <= '0;
         age_q  <= '0;
      end else begin
         case (st_q)
            GS_SHUT: begin
               if (!fault && ce_in_n) st_q <= GS_RUN;
            end
            GS_RUN: begin
               if (fault) begin
                  if (!ce_in_n) begin
                     st_q   <= GS_GRACE;
                     held_q <= bank_sel;
                     age_q  <= '0;
                  end else begin
                     st_q <= GS_SHUT;
                  end
               end
            end
            GS_GRACE: begin
               if (ce_in_n || age_done) st_q <= GS_SHUT;
               else                     age_q <= age_q + 1'b1;
            end
            default: st_q <= GS_SHUT;
         endcase
      end
   end

   assign state    = st_q;
   assign held_sel = held_q;

endmodule

// File: rtl/nvg_bank_decode.sv
module nvg_bank_decode
   import nvg_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   localparam int SEL_W = $clog2(NUM_BANKS)
) (
   input  guard_state_e         state,
   input  logic                 ce_in_n,
   input  logic [SEL_W-1:0]     bank_sel,
   input  logic [SEL_W-1:0]     held_sel,
   output logic [NUM_BANKS-1:0] bank_ce_n
);

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         localparam logic [SEL_W-1:0] IDX = SEL_W'(b);
         logic hit;

         always_comb begin
            case (state)
               GS_RUN:   hit = (bank_sel == IDX);
               GS_GRACE: hit = (held_sel == IDX);
               default:  hit = 1'b0;
            endcase
         end

         assign bank_ce_n[b] = ~(hit & ~ce_in_n);
      end
   endgenerate

endmodule

// File: rtl/nvg_bank_guard.sv
module nvg_bank_guard
   import nvg_pkg::*;
#(
   parameter int NUM_BANKS    = 4,
   parameter int GRACE_CYCLES = 8,
   localparam int SEL_W = $clog2(NUM_BANKS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [SEL_W-1:0]     bank_sel,
   input  logic                 ce_in_n,
   input  logic                 wide_tol,
   input  logic                 trip_tight,
   input  logic                 trip_wide,
   output logic [NUM_BANKS-1:0] bank_ce_n
);

   generate
      if (NUM_BANKS < 2 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_banks
         $error("NUM_BANKS must be a power of two, at least 2");
      end
      if (GRACE_CYCLES < 1) begin : g_bad_grace
         $error("GRACE_CYCLES must be at least 1");
      end
   endgenerate

   logic             fault;
   guard_state_e     state;
   logic [SEL_W-1:0] held_sel;

   nvg_trip_pick #(.NUM_LEVELS(2)) u_pick (
      .trip_vec  ({trip_wide, trip_tight}),
      .level_sel (wide_tol),
      .fault     (fault)
   );

   nvg_guard_fsm #(.SEL_W(SEL_W), .GRACE_CYCLES(GRACE_CYCLES)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .fault    (fault),
      .ce_in_n  (ce_in_n),
      .bank_sel (bank_sel),
      .state    (state),
      .held_sel (held_sel)
   );

   nvg_bank_decode #(.NUM_BANKS(NUM_BANKS)) u_dec (
      .state     (state),
      .ce_in_n   (ce_in_n),
      .bank_sel  (bank_sel),
      .held_sel  (held_sel),
      .bank_ce_n (bank_ce_n)
   );

endmodule

// File: rtl/nvg_guard_chk.sv
module nvg_guard_chk #(
   parameter int NUM_BANKS    = 4,
   parameter int GRACE_CYCLES = 8,
   localparam int SEL_W = $clog2(NUM_BANKS),
   localparam int RUN_W = $clog2(GRACE_CYCLES + 2) + 1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [SEL_W-1:0]     bank_sel,
   input logic                 ce_in_n,
   input logic                 wide_tol,
   input logic                 trip_tight,
   input logic                 trip_wide,
   input logic [NUM_BANKS-1:0] bank_ce_n
);

   localparam logic [RUN_W-1:0] RUN_CAP = RUN_W'(GRACE_CYCLES + 1);

   logic             supply_bad;
   logic [RUN_W-1:0] low_run;
   logic             unused_sel;

   assign supply_bad = wide_tol ? trip_wide : trip_tight;
   assign unused_sel = ^bank_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     low_run <= '0;
      else if (!supply_bad || ce_in_n) low_run <= '0;
      else if (low_run != RUN_CAP)     low_run <= low_run + 1'b1;
   end

   always @(negedge clk) begin
      if (!rst_n) begin
         AST_RESET_SHUT: assert (&bank_ce_n); // R1
      end
   end

   AST_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~bank_ce_n) <= 1); // R9

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ce_in_n |-> &bank_ce_n); // R2

   AST_IDLE_FAULT_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
      (supply_bad && ce_in_n) |=> &bank_ce_n); // R4

   AST_GRACE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (low_run == RUN_CAP) |-> &bank_ce_n); // R7

endmodule

bind nvg_bank_guard nvg_guard_chk #(
   .NUM_BANKS    (NUM_BANKS),
   .GRACE_CYCLES (GRACE_CYCLES)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bank_sel   (bank_sel),
   .ce_in_n    (ce_in_n),
   .wide_tol   (wide_tol),
   .trip_tight (trip_tight),
   .trip_wide  (trip_wide),
   .bank_ce_n  (bank_ce_n)
);

// File: tb/sim_nvg_bank_guard.sv
`timescale 1ns/1ps
module sim_nvg_bank_guard;

   localparam int NB = 4;
   localparam int G  = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    bank_sel = '0;
   logic          ce_in_n = 1'b1;
   logic          wide_tol = 1'b0;
   logic          trip_tight = 1'b0;
   logic          trip_wide = 1'b0;
   logic [NB-1:0] bank_ce_n;

   int    total = 0;
   int    bad = 0;
   bit    done = 0;
   string cur_req = "R1";

   // reference: 0 = shut, 1 = running, 2 = grace
   int m_mode = 0;
   int m_bank = 0;
   int m_age  = 0;

   always #2.5 clk = ~clk;

   nvg_bank_guard #(.NUM_BANKS(NB), .GRACE_CYCLES(G)) u0 (
      .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel), .ce_in_n(ce_in_n),
      .wide_tol(wide_tol), .trip_tight(trip_tight), .trip_wide(trip_wide),
      .bank_ce_n(bank_ce_n)
   );

   always @(posedge clk) begin
      bit flt;
      flt = wide_tol ? trip_wide : trip_tight;
      if (!rst_n) begin
         m_mode = 0;
      end else begin
         if (m_mode == 0) begin
            if (!flt && ce_in_n) m_mode = 1;
         end else if (m_mode == 1) begin
            if (flt) begin
               if (!ce_in_n) begin m_mode = 2; m_bank = int'(bank_sel); m_age = 0; end
               else m_mode = 0;
            end
         end else begin
            if (ce_in_n) m_mode = 0;
            else begin
               m_age++;
               if (m_age >= G) m_mode = 0;
            end
         end
      end
   end

   function automatic logic [NB-1:0] expect_out();
      logic [NB-1:0] e;
      e = '1;
      if (!ce_in_n) begin
         if (m_mode == 1) e[bank_sel] = 1'b0;
         else if (m_mode == 2) e[m_bank] = 1'b0;
      end
      return e;
   endfunction

   task automatic check(string req, logic [NB-1:0] act, logic [NB-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: bank_ce_n=%b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         check(cur_req, bank_ce_n, expect_out());
         total++;
         if ($countones(~bank_ce_n) > 1) begin
            bad++;
            $display("FAIL R9: bank_ce_n=%b expected at most one low", bank_ce_n);
         end
      end
   end

   task automatic step(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   initial begin
      cur_req = "R1";
      step(3);
      check("R1", bank_ce_n, 4'b1111);
      rst_n = 1'b1;
      step(1);
      check("R1", bank_ce_n, 4'b1111);

      // normal decode across every bank
      cur_req = "R2";
      step(1);
      for (int b = 0; b < NB; b++) begin
         bank_sel = 2'(b); ce_in_n = 1'b0; step(2);
         ce_in_n = 1'b1; step(1);
      end

      // unselected flag toggles during accesses
      cur_req = "R3";
      wide_tol = 1'b0; trip_wide = 1'b1; bank_sel = 2'd1; ce_in_n = 1'b0; step(3);
      ce_in_n = 1'b1; trip_wide = 1'b0; step(1);
      wide_tol = 1'b1; trip_tight = 1'b1; bank_sel = 2'd3; ce_in_n = 1'b0; step(3);
      ce_in_n = 1'b1; trip_tight = 1'b0; step(1);
      wide_tol = 1'b0;

      // fault while idle, then try to access
      cur_req = "R4";
      trip_tight = 1'b1; step(1);
      bank_sel = 2'd2; ce_in_n = 1'b0; step(3);

      // recovery needs fault clear and idle request
      cur_req = "R8";
      trip_tight = 1'b0; step(3);
      check("R8", bank_ce_n, 4'b1111);
      ce_in_n = 1'b1; step(1);
      ce_in_n = 1'b0; bank_sel = 2'd0;
      #0.5; check("R8", bank_ce_n, 4'b1110);
      step(1);
      ce_in_n = 1'b1; step(1);

      // grace access stays on captured bank, ends on idle request
      cur_req = "R5";
      bank_sel = 2'd2; ce_in_n = 1'b0; step(1);
      trip_tight = 1'b1; step(1);
      bank_sel = 2'd0; step(2);
      check("R5", bank_ce_n, 4'b1011);
      cur_req = "R6";
      ce_in_n = 1'b1; step(1);
      ce_in_n = 1'b0; bank_sel = 2'd2; step(2);
      check("R6", bank_ce_n, 4'b1111);
      ce_in_n = 1'b1; trip_tight = 1'b0; step(2);

      // grace timeout with request held low
      cur_req = "R7";
      bank_sel = 2'd1; ce_in_n = 1'b0; step(1);
      trip_tight = 1'b1; step(G - 1);
      check("R7", bank_ce_n, 4'b1101);
      step(3);
      check("R7", bank_ce_n, 4'b1111);
      ce_in_n = 1'b1; trip_tight = 1'b0; step(2);

      // wide tolerance flag does trigger when selected
      cur_req = "R3";
      wide_tol = 1'b1; bank_sel = 2'd3; ce_in_n = 1'b0; step(1);
      trip_wide = 1'b1; step(G + 2);
      check("R3", bank_ce_n, 4'b1111);
      ce_in_n = 1'b1; trip_wide = 1'b0; step(2);
      ce_in_n = 1'b0; step(1);
      check("R3", bank_ce_n, 4'b0111);
      ce_in_n = 1'b1; step(1);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         total++; bad++;
         $display("FAIL watchdog: run did not end, expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule